// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Responder

This block is the peripheral side of a vectored interrupt acknowledge on a multiplexed bus. The bus uses an address strobe and a data strobe. Both strobes are oversampled in the system clock domain. At the end of the address phase, when the address strobe rises, the block latches whether the cycle is an interrupt acknowledge. Once the data strobe falls, the block decides whether the acknowledge belongs to it. It takes that decision from the latched flag, its own pending sources, and the enable that arrives on the priority chain (`iei`).

When it wins, the block drives an 8-bit vector for the time the data strobe stays low. The low bits of that vector carry the index of the winning source. The block also marks that source as under service. Devices further down the chain see `ieo` low whenever this block has a source in service, or has a pending source during an acknowledge cycle. A clear command releases the under-service marks one at a time, highest first.

Top module: `intack_daisy`

## Requirements
- R1: Both strobes pass through a two-flop synchronizer. When `as_n` rises, the block latches `intack_n`: low marks an acknowledge cycle. A change on `intack_n` after that edge has no effect until the next rise of `as_n`.
- R2: The respond decision uses the value of `iei` at the falling edge of `ds_n`, not its value at the rise of `as_n`.
- R3: The block claims the acknowledge only in an acknowledge cycle, with at least one pending source and `iei` high when `ds_n` falls. When it claims, `data_oe` goes high and `vec_out` = {`vec_hi`, index}, with the index in bits 2:0 for the default of 8 sources.
- R4: With several sources pending, the highest-indexed one wins.
- R5: A claim sets the under-service mark of the winning source. A source under service does not count as pending.
- R6: `data_oe` drops once `ds_n` rises. `vec_out` holds steady while `data_oe` is high.
- R7: `ieo` is high only when `iei` is high, no under-service mark is set, and there is no pending source during an acknowledge cycle. Outside an acknowledge cycle, pending sources do not pull `ieo` low.
- R8: `irq_out` is high when a source is pending and no under-service mark is set.
- R9: A one-cycle pulse on `clr_ius` clears only the highest-indexed under-service mark that is set.
- R10: After reset, `data_oe` and `irq_out` are low, no mark is set, and `ieo` follows `iei`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low reset |
| as_n | input | 1 | address strobe, asynchronous |
| ds_n | input | 1 | data strobe, asynchronous, low during the data phase |
| intack_n | input | 1 | acknowledge indication, latched when `as_n` rises |
| iei | input | 1 | daisy-chain enable in |
| irq_src | input | NSRC | interrupt request sources |
| vec_hi | input | 8-log2(NSRC) | fixed upper bits of the vector |
| clr_ius | input | 1 | clear highest under-service mark |
| data_oe | output | 1 | data bus drive enable |
| vec_out | output | 8 | vector driven during a claim |
| ieo | output | 1 | daisy-chain enable out |
| irq_out | output | 1 | interrupt request |

## Verification
A table of acknowledge cycles varies the following:
- single sources at both ends of the index range, which separates the index encoding from the fixed upper bits;
- mixed request patterns, which show the priority order;
- an empty request set, which tests the pending condition;
- a low chain enable, which tests blocking from upstream;
- a cycle that is not an acknowledge, which shows that the latched flag and not the data strobe gates the response.

Directed sequences cover two changes made after the address strobe has risen. Moving `iei` in that window shows the decision is taken at the data-strobe fall. Flipping `intack_n` in that window shows it is latched. Two marks set at once, then cleared with single pulses, reveal which mark each pulse releases through the vector of the next claim.

// File: rtl/intack_daisy.sv
module intack_daisy #(
  parameter int NSRC = 8,
  parameter int VW   = 8,
  parameter int IW   = $clog2(NSRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               as_n,
  input  logic               ds_n,
  input  logic               intack_n,
  input  logic               iei,
  input  logic [NSRC-1:0]    irq_src,
  input  logic [VW-IW-1:0]   vec_hi,
  input  logic               clr_ius,
  output logic               data_oe,
  output logic [VW-1:0]      vec_out,
  output logic               ieo,
  output logic               irq_out
);

  logic [1:0] as_sy, ds_sy;
  logic as_q, ds_q, ack_q;
  logic [NSRC-1:0] ius, pend, ius_clr;
  logic [IW-1:0] win;
  logic as_rise, ds_fall, ds_rise, any_pend, claim;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      as_sy <= 2'b11;
      ds_sy <= 2'b11;
      as_q  <= 1'b1;
      ds_q  <= 1'b1;
    end else begin
      as_sy <= {as_sy[0], as_n};
      ds_sy <= {ds_sy[0], ds_n};
      as_q  <= as_sy[1];
      ds_q  <= ds_sy[1];
    end

  assign as_rise = as_sy[1] & ~as_q;
  assign ds_fall = ~ds_sy[1] & ds_q;
  assign ds_rise = ds_sy[1] & ~ds_q;

  assign pend     = irq_src & ~ius;
  assign any_pend = |pend;
  assign claim    = ds_fall & ack_q & any_pend & iei;

  always_comb begin
    win = '0;
    for (int i = 0; i < NSRC; i++)
      if (pend[i]) win = IW'(i);
  end

  always_comb begin
    ius_clr = '0;
    for (int i = 0; i < NSRC; i++)
      if (ius[i]) ius_clr = NSRC'(1) << i;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_q   <= 1'b0;
      data_oe <= 1'b0;
      vec_out <= '0;
      ius     <= '0;
    end else begin
      if (as_rise) ack_q <= ~intack_n;
      if (claim) begin
        data_oe <= 1'b1;
        vec_out <= {vec_hi, win};
      end else if (ds_rise) begin
        data_oe <= 1'b0;
      end
      ius <= (ius & ~(clr_ius ? ius_clr : '0)) | (claim ? (NSRC'(1) << win) : '0);
    end

  assign ieo     = iei & ~(|ius) & ~(ack_q & any_pend);
  assign irq_out = any_pend & ~(|ius);

  assert_claim_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> ack_q && $past(iei) && $past(|(irq_src & ~ius)));

  assert_claim_marks_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> ius[vec_out[IW-1:0]]);

  assert_claim_blocks_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> !ieo);

  assert_claim_masks_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> !irq_out);

  assert_release_on_ds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ds_rise && !claim |=> !data_oe);

  assert_vector_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe && $past(data_oe) |-> $stable(vec_out));

  assert_clear_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ius && !claim && (|ius) |=> $countones(ius) == $countones($past(ius)) - 1);

endmodule

// File: tb/intack_daisy_bench.sv
module intack_daisy_bench;
  logic clk = 0, rst_n = 0;
  logic as_n = 1, ds_n = 1, intack_n = 1, iei = 1, clr_ius = 0;
  logic [7:0] irq_src = 0;
  logic [4:0] vec_hi = 5'b10101;
  logic data_oe, ieo, irq_out;
  logic [7:0] vec_out;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  intack_daisy u_intack_daisy (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .intack_n(intack_n),
    .iei(iei), .irq_src(irq_src), .vec_hi(vec_hi), .clr_ius(clr_ius),
    .data_oe(data_oe), .vec_out(vec_out), .ieo(ieo), .irq_out(irq_out));

  // src, iei, ack, claim, vec, ieo while ds low
  localparam logic [19:0] TBL [6] = '{
    {8'h01, 1'b1, 1'b1, 1'b1, 8'hA8, 1'b0},
    {8'h84, 1'b1, 1'b1, 1'b1, 8'hAF, 1'b0},
    {8'h12, 1'b1, 1'b1, 1'b1, 8'hAC, 1'b0},
    {8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1},
    {8'h01, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},
    {8'h40, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1}
  };

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic as_phase(logic ack);
    intack_n = ~ack; as_n = 0; wt(3); as_n = 1; wt(6);
  endtask

  task automatic clear_all();
    for (int k = 0; k < 8; k++) begin clr_ius = 1; wt(1); clr_ius = 0; wt(1); end
  endtask

  initial begin
    fork
      begin
        wt(3); rst_n = 1; wt(2);
        chk("R10 data_oe", {7'b0, data_oe}, 8'h0);
        chk("R10 irq_out", {7'b0, irq_out}, 8'h0);
        chk("R10 ieo", {7'b0, ieo}, 8'h1);

        for (int v = 0; v < 6; v++) begin
          irq_src = TBL[v][19:12]; iei = TBL[v][11];
          as_phase(TBL[v][10]);
          ds_n = 0; wt(6);
          chk("R3/R4 oe", {7'b0, data_oe}, {7'b0, TBL[v][9]});
          if (TBL[v][9]) chk("R3/R4 vector", vec_out, TBL[v][8:1]);
          chk("R7 ieo", {7'b0, ieo}, {7'b0, TBL[v][0]});
          ds_n = 1; wt(6);
          chk("R6 oe drop", {7'b0, data_oe}, 8'h0);
          irq_src = 0; iei = 1; clear_all();
        end

        irq_src = 8'h01; wt(2);
        chk("R8 request", {7'b0, irq_out}, 8'h1);
        as_phase(1);
        chk("R7 pending in ack", {7'b0, ieo}, 8'h0);
        ds_n = 0; wt(6); ds_n = 1; wt(6);
        chk("R8 masked", {7'b0, irq_out}, 8'h0);
        chk("R5 ieo under service", {7'b0, ieo}, 8'h0);
        as_phase(1); ds_n = 0; wt(6);
        chk("R5 no reclaim", {7'b0, data_oe}, 8'h0);
        ds_n = 1; wt(6); irq_src = 0; clear_all();

        irq_src = 8'h08; iei = 0; as_phase(1); iei = 1; wt(2);
        ds_n = 0; wt(6);
        chk("R2 late iei claim", vec_out, 8'hAB);
        ds_n = 1; wt(6); irq_src = 0; clear_all();
        irq_src = 8'h08; iei = 1; as_phase(1); iei = 0; wt(2);
        ds_n = 0; wt(6);
        chk("R2 dropped iei", {7'b0, data_oe}, 8'h0);
        ds_n = 1; wt(6); iei = 1;

        as_phase(1); intack_n = 1; wt(2);
        ds_n = 0; wt(6);
        chk("R1 latched ack", {7'b0, data_oe}, 8'h1);
        ds_n = 1; wt(6); irq_src = 0; clear_all();
        irq_src = 8'h08; as_phase(0); intack_n = 0; wt(2);
        ds_n = 0; wt(6);
        chk("R1 late intack", {7'b0, data_oe}, 8'h0);
        ds_n = 1; wt(6);

        irq_src = 8'h04; as_phase(1); ds_n = 0; wt(6); ds_n = 1; wt(6);
        irq_src = 8'h20; as_phase(1); ds_n = 0; wt(6); ds_n = 1; wt(6);
        clr_ius = 1; wt(1); clr_ius = 0; wt(2);
        irq_src = 8'h24; as_phase(1); ds_n = 0; wt(6);
        chk("R9 highest cleared", vec_out, 8'hAD);
        ds_n = 1; wt(6);
        irq_src = 8'h00;
        clr_ius = 1; wt(1); clr_ius = 0; wt(1);
        clr_ius = 1; wt(1); clr_ius = 0; wt(2);
        irq_src = 8'h04; wt(2);
        chk("R9 all cleared", {7'b0, irq_out}, 8'h1);
      end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule